// File: doc/BRIEF.md
# Protocol Discovery Enumerator with Support Lookup

This block runs on the host side of a request/response mailbox. It learns which protocols the mailbox carries by issuing discovery exchanges through a requester interface. Each exchange sends a single dword that holds an index. The single dword that comes back names one protocol as a vendor ID and type pair, and it also gives the index to ask for next. The block appends every returned pair to a table of `N_ENTRIES` slots. The walk stops when the next index is zero, or when a failure or a full table cuts it short.

Alongside the walk, a purely combinational lookup says whether a given vendor ID and type pair is supported. The discovery protocol (vendor ID 0x0001, type 0x00) is always reported as supported, including before any walk. Any other pair counts as supported only if it matches a stored entry exactly. A qualified query also steers a task to either a pass output or an invalid-argument output, so an unsupported task never reaches the mailbox.

Top module: `disc_enum`

## Requirements
- R1: After reset the block is idle (`en_busy`=0, `en_done`=0), `en_status`=0, `en_count`=0 and `rq_start`=0, and the discovery pair (0x0001, 0x00) already looks up as supported.
- R2: Every request carries vendor 0x0001 and type 0x00. The index sits in payload bits [7:0] and payload bits [31:8] are zero. The first request of a walk uses index 0.
- R3: A good response has `rq_ok`=1 and `rq_resp_len`=1. Its dword gives the vendor ID in [15:0], the type in [23:16] and the next index in [31:24]. The pair is appended to the table and `en_count` goes up by one. A nonzero next index becomes the index of the following request. A zero next index ends the walk with `en_status`=0 (success).
- R4: `rq_start` is a single-cycle pulse, and no new pulse occurs while a request is still awaiting `rq_done`.
- R5: A response whose length is not exactly one dword ends the walk with `en_status`=2, and its pair is not appended.
- R6: A response with `rq_ok`=0 ends the walk with `en_status`=1, and its pair is not appended.
- R7: If the table becomes full (`en_count`=`N_ENTRIES`) while the next index is still nonzero, the walk ends with `en_status`=3 and no further request is issued.
- R8: `q_hit` follows `q_vid`/`q_type` in the same cycle. It is 1 for the discovery pair, and otherwise 1 only when both fields equal one of the first `en_count` stored entries.
- R9: With `q_valid`=1, exactly one of `q_pass` (supported) or `q_inval` (unsupported, invalid-argument) is 1. With `q_valid`=0, both are 0.
- R10: An `en_start` accepted while idle empties the table, so entries from an earlier walk no longer hit. An `en_start` asserted during a walk has no effect.
- R11: `en_busy` is 1 from the cycle after an accepted `en_start` until the final response is consumed. In the cycle after that, `en_done` pulses for one cycle with `en_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_start | input | 1 | Begin a new enumeration walk |
| en_busy | output | 1 | Walk in progress |
| en_done | output | 1 | One-cycle pulse when a walk ends |
| en_status | output | 2 | Result of last walk: 0 ok, 1 transfer fail, 2 bad length, 3 overflow |
| en_count | output | CNT_W | Number of valid table entries |
| rq_start | output | 1 | Request pulse toward the requester |
| rq_vendor | output | 16 | Request vendor ID (always 0x0001) |
| rq_type | output | 8 | Request type (always 0x00) |
| rq_payload | output | 32 | Request payload dword carrying the index |
| rq_done | input | 1 | Requester finished the exchange |
| rq_ok | input | 1 | Exchange completed without transfer error |
| rq_resp_len | input | LEN_W | Response payload length in dwords |
| rq_resp_data | input | 32 | First response payload dword |
| q_valid | input | 1 | Task submission qualifier |
| q_vid | input | 16 | Queried vendor ID |
| q_type | input | 8 | Queried protocol type |
| q_hit | output | 1 | Pair is supported |
| q_pass | output | 1 | Qualified task may be submitted |
| q_inval | output | 1 | Qualified task rejected as invalid argument |

## Verification
The bench builds the block with `N_ENTRIES`=4, so every walk length from 1 up to one past capacity can be swept. That sweep reaches a walk that exactly fills the table and ends cleanly, as well as the overflow case. The small table also lets every stored pair, its neighbours and stale pairs from earlier walks be probed after each walk. Transfer failures and both wrong-length responses are injected at different steps of a walk, and a restart is pressed in the middle of a walk.

// File: rtl/disc_pkg.sv
package disc_pkg;

    localparam logic [15:0] DISC_VID  = 16'h0001;
    localparam logic [7:0]  DISC_TYPE = 8'h00;

    typedef struct packed {
        logic [15:0] vid;
        logic [7:0]  ptype;
    } proto_t;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_XFER = 2'd1,
        ST_LEN  = 2'd2,
        ST_OVF  = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2
    } walk_e;

endpackage

// File: rtl/disc_table.sv
module disc_table
    import disc_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int CNT_W     = $clog2(N_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  proto_t           wr_ent,
    input  proto_t           q_ent,
    output logic             q_hit,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        proto_t [N_ENTRIES-1:0] ent;
        logic   [CNT_W-1:0]     cnt;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [N_ENTRIES-1:0] match;

    always_comb begin
        tbl_d = tbl_q;
        if (clr) begin
            tbl_d.cnt = '0;
        end else if (wr_en && (tbl_q.cnt < CNT_W'(N_ENTRIES))) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (tbl_q.cnt == CNT_W'(i)) begin
                    tbl_d.ent[i] = wr_ent;
                end
            end
            tbl_d.cnt = tbl_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // One comparator per slot; slots at or above the count never match.
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        assign match[i] = (CNT_W'(i) < tbl_q.cnt) && (tbl_q.ent[i] == q_ent);
    end

    assign q_hit = |match;
    assign count = tbl_q.cnt;

endmodule

// File: rtl/disc_walker.sv
module disc_walker
    import disc_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int CNT_W     = $clog2(N_ENTRIES + 1),
    parameter int LEN_W     = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             resp_done,
    input  logic             resp_ok,
    input  logic [LEN_W-1:0] resp_len,
    input  logic [31:0]      resp_data,
    input  logic [CNT_W-1:0] tbl_cnt,
    output logic             tbl_clr,
    output logic             tbl_wr,
    output proto_t           tbl_ent,
    output logic             req_start,
    output logic [31:0]      req_payload,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status
);

    typedef struct packed {
        walk_e      st;
        logic [7:0] idx;
        logic       done;
        status_e    status;
    } walk_t;

    walk_t w_d, w_q;
    logic [7:0] nxt_idx;
    logic       last_slot;

    assign nxt_idx   = resp_data[31:24];
    assign last_slot = (tbl_cnt == CNT_W'(N_ENTRIES - 1));
    assign tbl_ent   = '{vid: resp_data[15:0], ptype: resp_data[23:16]};

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        tbl_clr  = 1'b0;
        tbl_wr   = 1'b0;
        unique case (w_q.st)
            W_IDLE: begin
                if (start) begin
                    w_d.st     = W_ISSUE;
                    w_d.idx    = 8'h00;
                    w_d.status = ST_OK;
                    tbl_clr    = 1'b1;
                end
            end
            W_ISSUE: begin
                w_d.st = W_WAIT;
            end
            W_WAIT: begin
                if (resp_done) begin
                    if (!resp_ok) begin
                        w_d.st     = W_IDLE;
                        w_d.status = ST_XFER;
                        w_d.done   = 1'b1;
                    end else if (resp_len != LEN_W'(1)) begin
                        w_d.st     = W_IDLE;
                        w_d.status = ST_LEN;
                        w_d.done   = 1'b1;
                    end else begin
                        tbl_wr = 1'b1;
                        if (nxt_idx == 8'h00) begin
                            w_d.st     = W_IDLE;
                            w_d.status = ST_OK;
                            w_d.done   = 1'b1;
                        end else if (last_slot) begin
                            w_d.st     = W_IDLE;
                            w_d.status = ST_OVF;
                            w_d.done   = 1'b1;
                        end else begin
                            w_d.st  = W_ISSUE;
                            w_d.idx = nxt_idx;
                        end
                    end
                end
            end
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: W_IDLE, idx: 8'h00, done: 1'b0, status: ST_OK};
        end else begin
            w_q <= w_d;
        end
    end

    assign req_start   = (w_q.st == W_ISSUE);
    assign req_payload = {24'h000000, w_q.idx};
    assign busy        = (w_q.st != W_IDLE);
    assign done        = w_q.done;
    assign status      = w_q.status;

endmodule

// File: rtl/disc_enum.sv
module disc_enum
    import disc_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int LEN_W     = 19,
    localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_start,
    output logic             en_busy,
    output logic             en_done,
    output logic [1:0]       en_status,
    output logic [CNT_W-1:0] en_count,
    output logic             rq_start,
    output logic [15:0]      rq_vendor,
    output logic [7:0]       rq_type,
    output logic [31:0]      rq_payload,
    input  logic             rq_done,
    input  logic             rq_ok,
    input  logic [LEN_W-1:0] rq_resp_len,
    input  logic [31:0]      rq_resp_data,
    input  logic             q_valid,
    input  logic [15:0]      q_vid,
    input  logic [7:0]       q_type,
    output logic             q_hit,
    output logic             q_pass,
    output logic             q_inval
);

    logic   tbl_clr, tbl_wr, tbl_hit, disc_hit;
    proto_t tbl_ent;

    disc_walker #(
        .N_ENTRIES (N_ENTRIES),
        .CNT_W     (CNT_W),
        .LEN_W     (LEN_W)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (en_start),
        .resp_done   (rq_done),
        .resp_ok     (rq_ok),
        .resp_len    (rq_resp_len),
        .resp_data   (rq_resp_data),
        .tbl_cnt     (en_count),
        .tbl_clr     (tbl_clr),
        .tbl_wr      (tbl_wr),
        .tbl_ent     (tbl_ent),
        .req_start   (rq_start),
        .req_payload (rq_payload),
        .busy        (en_busy),
        .done        (en_done),
        .status      (en_status)
    );

    disc_table #(
        .N_ENTRIES (N_ENTRIES),
        .CNT_W     (CNT_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tbl_clr),
        .wr_en  (tbl_wr),
        .wr_ent (tbl_ent),
        .q_ent  ('{vid: q_vid, ptype: q_type}),
        .q_hit  (tbl_hit),
        .count  (en_count)
    );

    assign rq_vendor = DISC_VID;
    assign rq_type   = DISC_TYPE;

    // Discovery support is built in and never depends on the table.
    assign disc_hit = (q_vid == DISC_VID) && (q_type == DISC_TYPE);
    assign q_hit    = disc_hit || tbl_hit;
    assign q_pass   = q_valid && q_hit;
    assign q_inval  = q_valid && !q_hit;

endmodule

// File: rtl/disc_enum_chk.sv
module disc_enum_chk #(
    parameter int N_ENTRIES = 8,
    parameter int LEN_W     = 19,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_busy,
    input logic             en_done,
    input logic [1:0]       en_status,
    input logic [CNT_W-1:0] en_count,
    input logic             rq_start,
    input logic             rq_done,
    input logic             rq_ok,
    input logic [LEN_W-1:0] rq_resp_len,
    input logic             q_valid,
    input logic [15:0]      q_vid,
    input logic [7:0]       q_type,
    input logic             q_hit,
    input logic             q_pass,
    input logic             q_inval
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (rq_start) begin
            pend_q <= 1'b1;
        end else if (rq_done) begin
            pend_q <= 1'b0;
        end
    end

    // R4
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rq_start |=> !rq_start);
    a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rq_start |-> !pend_q);

    // R5
    a_r5_bad_length: assert property (@(posedge clk) disable iff (!rst_n)
        (en_busy && pend_q && rq_done && rq_ok && rq_resp_len != LEN_W'(1))
        |=> (!en_busy && en_status == 2'd2));

    // R6
    a_r6_xfer_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (en_busy && pend_q && rq_done && !rq_ok)
        |=> (!en_busy && en_status == 2'd1));

    // R7
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en_count <= CNT_W'(N_ENTRIES));

    // R8
    a_r8_disc_always: assert property (@(posedge clk) disable iff (!rst_n)
        (q_vid == 16'h0001 && q_type == 8'h00) |-> q_hit);

    // R9
    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> $onehot({q_pass, q_inval}));
    a_r9_quiet_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (!q_pass && !q_inval));

    // R11
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        en_done |-> !en_busy);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        en_done |=> !en_done);

endmodule

bind disc_enum disc_enum_chk #(
    .N_ENTRIES (N_ENTRIES),
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_busy     (en_busy),
    .en_done     (en_done),
    .en_status   (en_status),
    .en_count    (en_count),
    .rq_start    (rq_start),
    .rq_done     (rq_done),
    .rq_ok       (rq_ok),
    .rq_resp_len (rq_resp_len),
    .q_valid     (q_valid),
    .q_vid       (q_vid),
    .q_type      (q_type),
    .q_hit       (q_hit),
    .q_pass      (q_pass),
    .q_inval     (q_inval)
);

// File: tb/disc_enum_tb.sv
module disc_enum_tb;

    localparam int N     = 4;
    localparam int LEN_W = 19;
    localparam int CNT_W = $clog2(N + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_start = 1'b0;
    logic             en_busy, en_done;
    logic [1:0]       en_status;
    logic [CNT_W-1:0] en_count;
    logic             rq_start;
    logic [15:0]      rq_vendor;
    logic [7:0]       rq_type;
    logic [31:0]      rq_payload;
    logic             rq_done = 1'b0;
    logic             rq_ok = 1'b0;
    logic [LEN_W-1:0] rq_resp_len = '0;
    logic [31:0]      rq_resp_data = '0;
    logic             q_valid = 1'b0;
    logic [15:0]      q_vid = '0;
    logic [7:0]       q_type = '0;
    logic             q_hit, q_pass, q_inval;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    disc_enum #(.N_ENTRIES(N), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_start(en_start), .en_busy(en_busy),
        .en_done(en_done), .en_status(en_status), .en_count(en_count),
        .rq_start(rq_start), .rq_vendor(rq_vendor), .rq_type(rq_type),
        .rq_payload(rq_payload), .rq_done(rq_done), .rq_ok(rq_ok),
        .rq_resp_len(rq_resp_len), .rq_resp_data(rq_resp_data),
        .q_valid(q_valid), .q_vid(q_vid), .q_type(q_type),
        .q_hit(q_hit), .q_pass(q_pass), .q_inval(q_inval)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] idx_of(input int s);
        return (s == 0) ? 8'h00 : 8'(8'h10 + s);
    endfunction
    function automatic logic [15:0] vid_of(input int l, input int s);
        return 16'(16'h1000 * l + 16'h0100 + s);
    endfunction
    function automatic logic [7:0] type_of(input int s);
        return 8'(8'h40 + s);
    endfunction

    task automatic lookup(input logic [15:0] v, input logic [7:0] t, input bit exp, input string tag);
        @(negedge clk);
        q_valid = 1'b1; q_vid = v; q_type = t;
        #1;
        check(q_hit == exp, {tag, " R8 hit"}, q_hit, exp);
        check(q_pass == exp && q_inval == !exp, {tag, " R9 pass/inval"},
              {q_pass, q_inval}, {exp, !exp});
        q_valid = 1'b0;
        #1;
        check(!q_pass && !q_inval, {tag, " R9 unqualified quiet"}, {q_pass, q_inval}, 0);
    endtask

    // fkind: 0 none, 1 transfer fail, 2 length 0, 3 length 2
    task automatic run_enum(input int L, input int fstep, input int fkind, input bit poke,
                            output int nreq);
        int step = 0;
        int guard = 0;
        bit fault;
        @(negedge clk);
        en_start = 1'b1;
        @(negedge clk);
        en_start = 1'b0;
        check(en_busy, "R11 busy after start", en_busy, 1);
        while (1) begin
            guard++;
            if (guard > 200) begin
                check(0, "R11 walk hung", guard, 0);
                break;
            end
            if (rq_start) begin
                check(rq_vendor == 16'h0001 && rq_type == 8'h00, "R2 request protocol",
                      {rq_vendor, rq_type}, 24'h000100);
                check(rq_payload == {24'h0, idx_of(step)}, "R2/R3 request index",
                      rq_payload, {24'h0, idx_of(step)});
                @(negedge clk);
                check(!rq_start, "R4 start is a pulse", rq_start, 0);
                if (poke) en_start = 1'b1;
                @(negedge clk);
                en_start = 1'b0;
                check(!rq_start, "R4 no start while pending", rq_start, 0);
                fault = (fkind != 0) && (step == fstep);
                rq_done = 1'b1;
                rq_ok = !(fault && fkind == 1);
                rq_resp_len = (fault && fkind == 2) ? LEN_W'(0) :
                              (fault && fkind == 3) ? LEN_W'(2) : LEN_W'(1);
                rq_resp_data = {((step + 1 < L) ? idx_of(step + 1) : 8'h00),
                                type_of(step), vid_of(L, step)};
                @(negedge clk);
                rq_done = 1'b0;
                step++;
                if (!en_busy) begin
                    check(en_done, "R11 done pulse", en_done, 1);
                    break;
                end
            end else if (!en_busy) begin
                break;
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        check(!en_done, "R11 done one cycle", en_done, 0);
        nreq = step;
    endtask

    initial begin
        int nreq, exp_req, exp_cnt, exp_st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(!en_busy && !en_done && !rq_start, "R1 idle after reset",
              {en_busy, en_done, rq_start}, 0);
        check(en_status == 0 && en_count == 0, "R1 status/count", {en_status, en_count}, 0);
        lookup(16'h0001, 8'h00, 1, "R1 discovery before walk");
        lookup(16'h0001, 8'h01, 0, "R8 wrong type");
        lookup(16'h0000, 8'h00, 0, "R8 wrong vid");
        lookup(vid_of(1, 0), type_of(0), 0, "R1 empty table");

        // R3 R7 sweep of walk lengths, one beyond capacity
        for (int L = 1; L <= N + 1; L++) begin
            run_enum(L, 0, 0, 0, nreq);
            exp_req = (L > N) ? N : L;
            exp_st  = (L > N) ? 3 : 0;
            check(nreq == exp_req, (L > N) ? "R7 request count" : "R3 request count", nreq, exp_req);
            check(en_status == 2'(exp_st), (L > N) ? "R7 overflow status" : "R3 ok status",
                  en_status, exp_st);
            check(en_count == CNT_W'(exp_req), "R3 entry count", en_count, exp_req);
            for (int s = 0; s <= exp_req; s++) begin
                lookup(vid_of(L, s), type_of(s), s < exp_req, "R3 stored pair");
                lookup(vid_of(L, s), type_of(s + 1), 0, "R8 type mismatch");
            end
            lookup(16'h0001, 8'h00, 1, "R8 discovery after walk");
        end

        // R6 R5 faults at various steps
        for (int k = 1; k <= 3; k++) begin
            run_enum(3, k - 1, k, 0, nreq);
            exp_cnt = k - 1;
            exp_st  = (k == 1) ? 1 : 2;
            check(nreq == k, (k == 1) ? "R6 stops after fail" : "R5 stops after bad length",
                  nreq, k);
            check(en_status == 2'(exp_st), (k == 1) ? "R6 xfer status" : "R5 length status",
                  en_status, exp_st);
            check(en_count == CNT_W'(exp_cnt), (k == 1) ? "R6 count" : "R5 count",
                  en_count, exp_cnt);
            lookup(vid_of(3, k - 1), type_of(k - 1), 0, "R5 faulty pair not stored");
        end

        // R10 start during a walk has no effect
        run_enum(3, 0, 0, 1, nreq);
        check(nreq == 3 && en_count == 3, "R10 mid-walk start ignored", {nreq, en_count}, 3);
        check(en_status == 0, "R10 status", en_status, 0);

        // R10 fresh start clears older entries
        run_enum(4, 0, 0, 0, nreq);
        run_enum(1, 0, 0, 0, nreq);
        check(en_count == 1, "R10 count after restart", en_count, 1);
        for (int s = 0; s < 4; s++) lookup(vid_of(4, s), type_of(s), 0, "R10 stale entry");
        lookup(vid_of(1, 0), type_of(0), 1, "R10 new entry");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule